// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Nibble-Packed Source Fields

This block collects requests from 28 interrupt sources and presents the CPU with the highest active priority level and the index of the source that holds it. Each source owns a 4-bit field inside one of four 32-bit control words. The low three bits of a field hold the priority, and zero masks the source. The top bit of a field is a write strobe: software changes a single source by writing a word in which only that field has its top bit set. All other fields in the word are left alone, so no read-modify-write is needed.

Six of the sources are external pins and are edge-detected. The first four sit in the top fields of control word 0, and the last two sit in control word 3 at bits 27:24 and 23:20. A polarity word picks rising or falling detection for each external pin. A detected edge is latched as pending until software acknowledges it, and any strobed write to that source's field does the acknowledge. The remaining sources are level-sensitive. Software reads back priorities and pending latches through the same register port.

Top module: `irq_nibble_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every control word and the polarity word read as zero, and `irq_level` and `irq_id` are both zero.
- R2: Source s lives in control word s/8 (address 0 to 3), at bits [31-4*(s%8) -: 4]. Field bits 2:0 are the priority. The polarity word is at address 4, and its bits 5:0 map in order to sources 0, 1, 2, 3, 25 and 26. Fields for slots 28 to 31 and unused polarity bits read as zero.
- R3: A write whose field bit 3 is zero leaves that field's priority unchanged. A write whose field bit 3 is one loads bits 2:0 of that field as the new priority.
- R4: A source with priority zero never requests. Writing 0x88888888 to all four control words masks every source and clears every pending edge.
- R5: A write with bit 3 set to an external source's field clears its pending latch. This holds whether the written priority equals the stored one or is zero.
- R6: An external source with polarity bit 1 latches pending on a rising pin edge, and with polarity bit 0 on a falling edge. The opposite edge latches nothing. The latch sets on the third rising clock edge after the pin changes, and `irq_level` follows one clock later.
- R7: A pending latch stays set after its pin returns, until it is acknowledged. Field bit 3 reads back the pending latch for external sources and reads zero for internal sources.
- R8: An internal source with nonzero priority requests while its input is high. The registered outputs reflect the input one clock edge after it is sampled.
- R9: `irq_level` is the highest priority among requesting sources, and `irq_id` is that source's index. Among equal priorities the lower index wins. With no requester both outputs are zero.
- R10: If an edge is detected in the same cycle as an acknowledge write to that source, the pending latch remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 to 3 control, 4 polarity) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_in | input | 28 | Source inputs: pins for external sources, levels for internal ones |
| irq_level | output | 3 | Highest active priority, 0 when idle |
| irq_id | output | 5 | Index of the winning source |

## Verification
A corrupted priority or pending latch shows up at the ports in two ways. It is visible on `rdata` in the same cycle its register is addressed. It also reaches `irq_level` and `irq_id` one clock after the arbiter samples it. A broken synchroniser or polarity choice shows as pending arriving at the wrong edge count, or not at all. That is observed by reading the field a fixed number of cycles after a pin change. A lost acknowledge or a lost coincident edge leaves a wrong bit 3 in the next read of the field.

// File: rtl/irqn_pkg.sv
// Package: shared constants and the external-source map of the controller.
// Assumes four control words of eight 4-bit fields, 28 of the 32 slots used.
package irqn_pkg;
    localparam int SRC_CNT  = 28;
    localparam int EXT_CNT  = 6;
    localparam int REG_CNT  = 4;
    localparam int FIELDS   = 8;
    localparam int NIB_W    = 4;
    localparam int PRIO_W   = NIB_W - 1;
    localparam int DATA_W   = FIELDS * NIB_W;
    localparam int ADDR_W   = 3;
    localparam int ID_W     = $clog2(SRC_CNT);
    localparam int SYNC_LEN = 2;
    localparam int POL_ADDR = REG_CNT;

    // Returns the external slot of source s, or -1 for a level source.
    function automatic int ext_of(input int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 3;
            25:      return 4;
            26:      return 5;
            default: return -1;
        endcase
    endfunction

    // Bit position of the least significant bit of source s in its word.
    function automatic int field_lsb(input int s);
        return (FIELDS - 1 - (s % FIELDS)) * NIB_W;
    endfunction
endpackage

// File: rtl/irqn_edge_det.sv
// Edge detector: a SYNC_LEN-flop synchroniser per external pin, then a
// registered copy for comparison. Polarity picks the rising or falling edge.
// Assumes pins are asynchronous to clk and the polarity input is quasi-static.
module irqn_edge_det #(
    parameter int N        = irqn_pkg::EXT_CNT,
    parameter int SYNC_LEN = irqn_pkg::SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] pol,
    output logic [N-1:0] hit
);
    for (genvar e = 0; e < N; e++) begin : g_pin
        logic [SYNC_LEN-1:0] sync_q;
        logic                prev_q;

        // Shift the pin through the synchroniser and keep one delayed copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_LEN-2:0], pin[e]};
                prev_q <= sync_q[SYNC_LEN-1];
            end
        end

        // Flag the selected transition between the delayed copy and the output.
        always_comb begin
            if (pol[e]) hit[e] = sync_q[SYNC_LEN-1] & ~prev_q;
            else        hit[e] = ~sync_q[SYNC_LEN-1] & prev_q;
        end
    end
endmodule

// File: rtl/irqn_field_bank.sv
// Field bank: holds the per-source priorities, the external pending latches and
// the polarity word, and decodes writes and reads. A field is updated only
// when its bit 3 is written as one, and that strobe also acknowledges pending.
// Assumes one register access per cycle. Reads are combinational.
module irqn_field_bank
    import irqn_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [EXT_CNT-1:0]        hit,
    output logic [SRC_CNT*PRIO_W-1:0] prio_flat,
    output logic [EXT_CNT-1:0]        pend,
    output logic [EXT_CNT-1:0]        pol,
    output logic [DATA_W-1:0]         rdata
);
    logic [SRC_CNT-1:0] src_pbit;

    for (genvar s = 0; s < SRC_CNT; s++) begin : g_src
        localparam int RIDX = s / FIELDS;
        localparam int LSB  = field_lsb(s);
        localparam int EIDX = ext_of(s);
        logic              strobe;
        logic [PRIO_W-1:0] prio_q;

        assign strobe = wr_en && (addr == ADDR_W'(RIDX)) && wdata[LSB+NIB_W-1];
        assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q;

        // Load the priority only when this field's strobe bit is written.
        always_ff @(posedge clk) begin
            if (!rst_n)      prio_q <= '0;
            else if (strobe) prio_q <= wdata[LSB +: PRIO_W];
        end

        if (EIDX >= 0) begin : g_ext
            logic pend_q;
            assign pend[EIDX]  = pend_q;
            assign src_pbit[s] = pend_q;

            // Latch a detected edge, clear on acknowledge; a new edge wins.
            always_ff @(posedge clk) begin
                if (!rst_n)         pend_q <= 1'b0;
                else if (hit[EIDX]) pend_q <= 1'b1;
                else if (strobe)    pend_q <= 1'b0;
            end
        end else begin : g_lvl
            assign src_pbit[s] = 1'b0;
        end
    end

    // Polarity word: written whole at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pol <= '0;
        else if (wr_en && addr == ADDR_W'(POL_ADDR)) pol <= wdata[EXT_CNT-1:0];
    end

    // Read mux: assemble the addressed word from fields or the polarity word.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(POL_ADDR)) begin
            rdata[EXT_CNT-1:0] = pol;
        end else begin
            for (int s = 0; s < SRC_CNT; s++) begin
                if (addr == ADDR_W'(s / FIELDS))
                    rdata[field_lsb(s) +: NIB_W] = {src_pbit[s], prio_flat[s*PRIO_W +: PRIO_W]};
            end
        end
    end
endmodule

// File: rtl/irqn_arbiter.sv
// Arbiter: finds the highest priority among requesting sources, with the
// lowest index winning ties, and registers level and index for the CPU.
// Assumes priority zero means masked, so a zero level means no request.
module irqn_arbiter
    import irqn_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SRC_CNT*PRIO_W-1:0] prio_flat,
    input  logic [SRC_CNT-1:0]        req,
    output logic [PRIO_W-1:0]         irq_level,
    output logic [ID_W-1:0]           irq_id
);
    logic [PRIO_W-1:0] best_lvl;
    logic [ID_W-1:0]   best_id;

    // Linear scan; strict compare keeps the earlier (lower) index on ties.
    always_comb begin
        best_lvl = '0;
        best_id  = '0;
        for (int s = 0; s < SRC_CNT; s++) begin
            if (req[s] && prio_flat[s*PRIO_W +: PRIO_W] > best_lvl) begin
                best_lvl = prio_flat[s*PRIO_W +: PRIO_W];
                best_id  = ID_W'(s);
            end
        end
    end

    // Register the result so the CPU sees a glitch-free level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= '0;
            irq_id    <= '0;
        end else begin
            irq_level <= best_lvl;
            irq_id    <= best_id;
        end
    end
endmodule

// File: rtl/irq_nibble_ctrl.sv
// Top: routes the external pins to the edge detector, forms the request
// vector from pending latches and level inputs, and drives the arbiter.
// Assumes src_in bits of external sources are raw asynchronous pins.
module irq_nibble_ctrl
    import irqn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [SRC_CNT-1:0]   src_in,
    output logic [PRIO_W-1:0]    irq_level,
    output logic [ID_W-1:0]      irq_id
);
    logic [EXT_CNT-1:0]        ext_pin;
    logic [EXT_CNT-1:0]        ext_hit;
    logic [EXT_CNT-1:0]        ext_pend;
    logic [EXT_CNT-1:0]        ext_pol;
    logic [SRC_CNT*PRIO_W-1:0] prio_flat;
    logic [SRC_CNT-1:0]        req;

    for (genvar s = 0; s < SRC_CNT; s++) begin : g_route
        localparam int EIDX = ext_of(s);
        if (EIDX >= 0) begin : g_ext
            assign ext_pin[EIDX] = src_in[s];
            assign req[s]        = ext_pend[EIDX];
        end else begin : g_lvl
            assign req[s] = src_in[s];
        end
    end

    irqn_edge_det #(.N(EXT_CNT), .SYNC_LEN(SYNC_LEN)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .pol   (ext_pol),
        .hit   (ext_hit)
    );

    irqn_field_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .hit       (ext_hit),
        .prio_flat (prio_flat),
        .pend      (ext_pend),
        .pol       (ext_pol),
        .rdata     (rdata)
    );

    irqn_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prio_flat (prio_flat),
        .req       (req),
        .irq_level (irq_level),
        .irq_id    (irq_id)
    );
endmodule

// File: rtl/irqn_checker.sv
// Checker: temporal properties on the controller's outputs and internal state,
// attached to the top module by bind.
module irqn_checker
    import irqn_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [PRIO_W-1:0]         irq_level,
    input logic [ID_W-1:0]           irq_id,
    input logic [SRC_CNT*PRIO_W-1:0] prio_flat,
    input logic [EXT_CNT-1:0]        pend,
    input logic [EXT_CNT-1:0]        hit
);
    // R3
    prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prio_flat));

    // R9
    idle_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == '0 |-> irq_id == '0);

    // R9
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_id < ID_W'(SRC_CNT));

    for (genvar e = 0; e < EXT_CNT; e++) begin : g_ext
        // R7
        pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && pend[e]) |=> pend[e]);

        // R6
        pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[e]) |-> $past(hit[e]));

        // R10
        edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[e] |=> pend[e]);
    end
endmodule

bind irq_nibble_ctrl irqn_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .irq_level (irq_level),
    .irq_id    (irq_id),
    .prio_flat (prio_flat),
    .pend      (ext_pend),
    .hit       (ext_hit)
);

// File: tb/irq_nibble_ctrl_tb.sv
module irq_nibble_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [27:0] src_in = '0;
    logic [2:0]  irq_level;
    logic [4:0]  irq_id;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [2:0] m_prio [28];
    bit         m_pend [28];
    logic [5:0] m_pol;

    always #5 clk = ~clk;

    irq_nibble_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_in(src_in), .irq_level(irq_level), .irq_id(irq_id)
    );

    function automatic bit is_ext(int s);
        return (s < 4) || (s == 25) || (s == 26);
    endfunction

    function automatic int lsb_of(int s);
        return 28 - 4 * (s % 8);
    endfunction

    function automatic logic [31:0] exp_reg(int a);
        logic [31:0] v = '0;
        if (a == 4) return {26'b0, m_pol};
        for (int s = 0; s < 28; s++)
            if (s / 8 == a) v[lsb_of(s) +: 4] = {is_ext(s) ? m_pend[s] : 1'b0, m_prio[s]};
        return v;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [2:0] best = '0;
        logic [4:0] id = '0;
        for (int s = 0; s < 28; s++) begin
            bit act = (m_prio[s] != 0) && (is_ext(s) ? m_pend[s] : src_in[s]);
            if (act && m_prio[s] > best) begin
                best = m_prio[s];
                id = 5'(s);
            end
        end
        return {best, id};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one register; the model follows the strobe rules (R3, R5).
    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 4) m_pol = d[5:0];
        else for (int s = 0; s < 28; s++)
            if (s / 8 == a && d[lsb_of(s) + 3]) begin
                m_prio[s] = d[lsb_of(s) +: 3];
                m_pend[s] = 1'b0;
            end
    endtask

    task automatic check_out(input string tag);
        @(negedge clk);
        chk(tag, {24'b0, irq_level, irq_id}, {24'b0, exp_out()});
    endtask

    task automatic check_reg(input string tag, input int a);
        addr = 3'(a);
        #1;
        chk(tag, rdata, exp_reg(a));
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 28; s++) begin m_prio[s] = '0; m_pend[s] = 0; end
        m_pol = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 5; a++) check_reg("R1 reset reg", a);
        chk("R1 reset outputs", {24'b0, irq_level, irq_id}, 32'h0);

        // R6 rising edge on source 0, prio 5
        do_write(4, 32'h3F);
        do_write(0, 32'hD000_0000);
        check_reg("R2 field layout src0", 0);
        @(negedge clk); src_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        m_pend[0] = 1;
        check_reg("R6 pending after three edges", 0);
        check_out("R6 rising edge request");
        // R7 pin returns, latch holds
        src_in[0] = 1'b0;
        settle();
        check_reg("R7 pending holds", 0);
        check_out("R7 request holds");
        // R5 acknowledge with same priority
        do_write(0, 32'hD000_0000);
        check_reg("R5 ack same prio", 0);
        check_out("R5 ack clears request");
        // R6 falling polarity: rise ignored, fall latches
        do_write(4, 32'h3E);
        @(negedge clk); src_in[0] = 1'b1;
        settle();
        check_reg("R6 opposite edge ignored", 0);
        src_in[0] = 1'b0;
        settle();
        m_pend[0] = 1;
        check_reg("R6 falling edge latched", 0);
        // R5 mask write clears pending
        do_write(0, 32'h8000_0000);
        check_reg("R5 mask clears pending", 0);
        check_out("R4 masked source idle");
        check_reg("R2 polarity word", 4);

        // R6 source 26 in word 3
        do_write(3, 32'h00B0_0000);
        @(negedge clk); src_in[26] = 1'b1;
        settle();
        m_pend[26] = 1;
        check_reg("R6 src26 pending", 3);
        check_out("R6 src26 request");

        // R8/R9 internal levels and ties
        do_write(0, 32'h0000_E000);
        do_write(1, 32'h0E00_0000);
        @(negedge clk); src_in[4] = 1'b1; src_in[9] = 1'b1;
        check_out("R8 level requests");
        check_out("R9 tie lower index");
        do_write(2, 32'h0000_F000);
        @(negedge clk); src_in[20] = 1'b1;
        check_out("R9 highest wins");
        do_write(0, 32'h0000_6000);
        check_out("R3 strobe-clear fields kept");
        check_reg("R3 word0 readback", 0);

        // R10 edge coinciding with acknowledge
        do_write(0, 32'h0A00_0000);
        @(negedge clk); src_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = 32'h0A00_0000;
        @(negedge clk);
        wr_en = 1'b0;
        m_pend[1] = 1;
        check_reg("R10 edge wins over ack", 0);
        check_out("R10 request kept");

        // R4 mask everything
        for (int a = 0; a < 4; a++) do_write(a, 32'h8888_8888);
        check_out("R4 all masked");
        for (int a = 0; a < 4; a++) check_reg("R4 all masked reg", a);
        check_reg("R2 empty slots word3", 3);

        // Random phase: external pins held, internal levels and writes random
        void'($urandom(32'h1357));
        for (int n = 0; n < 300; n++) begin
            int a = $urandom_range(0, 3);
            logic [31:0] d = $urandom;
            logic [27:0] lv = 28'($urandom);
            @(negedge clk);
            for (int s = 0; s < 28; s++) if (!is_ext(s)) src_in[s] = lv[s];
            do_write(a, d);
            check_out("R9 random arbitration");
            check_reg("R3 random readback", a);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule